// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block sits behind the read port of a small flash-style byte array and decides what a read returns while an internal program or erase is running. When nothing is running, a read returns the stored byte. While an operation is running, a read returns a status byte instead. Its top bit is a polarity flag that reads inverted until the work is done. Bit 6 flips on every read. Bit 5 is a failure flag that stays set until it is cleared. Bit 3 tells whether the erase itself has begun.

The block also owns the array. A program can only clear bits: the new byte is the AND of the old byte and the written byte. A program that asks for a 0 to become 1 never completes, and it times out into the failure state. An erase sets every byte of the chosen sectors to FFh. An operation aimed only at write-protected sectors shows status for a short time and then returns to plain reads without touching data. A separate timer or controller outside the block supplies the completion pulse. The command decoder outside the block supplies the start, kind and reset-command strobes.

Top module: `opst_status_gen`

## Requirements
- R1: After reset every byte reads FFh. With no operation running, a read strobe returns the byte at `rd_addr` on `rd_data` one clock later.
- R2: While a program (`op_kind` = 01) runs, a read returns the inverse of bit 7 of the programmed byte on bit 7, with bits 4..0 at 0. After `op_done` the programmed location reads back the written byte.
- R3: While an operation runs or has failed, bit 6 of each read flips relative to the previous read. The first read after each start shows 0, and reads with no operation running show array data.
- R4: A program that would raise any bit from 0 to 1 ignores `op_done`. Any operation still running after PULSE_LIMIT cycles enters the failure state. There, reads show bit 5 = 1, bit 7 stays inverted, and bit 6 keeps flipping.
- R5: The failure state holds until `rst_cmd`. After `rst_cmd`, reads return array data with the target byte unchanged, and the next operation starts with bit 5 = 0.
- R6: While a sector erase (`op_kind` = 10, sectors in `op_smask`) or a chip erase (`op_kind` = 11) runs, a read inside a selected sector returns bit 7 = 0 and bit 3 = NOT `win_open`, with bits 4, 2, 1 and 0 at 0. A read outside the selected sectors returns array data. The sector index is the top SW bits of the address.
- R7: When an erase completes, every byte of each selected, unprotected sector reads FFh, and all other bytes keep their values.
- R8: If every sector an operation targets is set in `prot_mask`, the data does not change. Status is returned for PROT_SHOW cycles, and then plain reads resume without `op_done`.
- R9: While an operation runs and has not failed, `op_start` and `rst_cmd` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start strobe for an operation |
| op_kind | input | 2 | 00 none, 01 program, 10 sector erase, 11 chip erase |
| op_addr | input | AW | Program address |
| op_data | input | 8 | Byte to program |
| op_smask | input | 2**SW | One bit per sector to erase |
| prot_mask | input | 2**SW | One bit per write-protected sector |
| op_done | input | 1 | Completion pulse from the operation timer |
| win_open | input | 1 | High while further sectors may still be added before erase begins |
| rst_cmd | input | 1 | Reset command; clears the failure state |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Array byte or status byte |

## Verification
The hardest situation to reach is the sticky failure. It needs a program that asks for a cleared bit to be set, followed by a wait longer than the pulse limit with no completion accepted. The stimulus first programs a byte down to a pattern with zeros. It then requests a value with one extra 1 bit and pulses `op_done` anyway, to show the pulse is ignored. After waiting out the limit, it reads the failure flag with bit 6 still alternating. A separate case lets a valid program time out without any `op_done`.

// File: rtl/opst_pkg.sv
package opst_pkg;

    typedef enum logic [1:0] {
        OPK_NONE   = 2'd0,
        OPK_PROG   = 2'd1,
        OPK_SERASE = 2'd2,
        OPK_CERASE = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_FAIL = 2'd2,
        ST_SHOW = 2'd3
    } ost_e;

    typedef struct packed {
        opk_e       kind;
        logic [7:0] pdata;
    } op_ctx_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // status while a program runs: inverted bit 7, toggle, fail flag
    function automatic logic [7:0] prog_status(logic pd7, logic tg, logic fl);
        return {~pd7, tg, fl, 5'b00000};
    endfunction

    // status while an erase runs: bit 3 high once the add-sector window closed
    function automatic logic [7:0] erase_status(logic tg, logic fl, logic win);
        return {1'b0, tg, fl, 1'b0, ~win, 3'b000};
    endfunction

    // true when programming want over cur would need a 0 -> 1 change
    function automatic logic raises_bit(logic [7:0] cur, logic [7:0] want);
        return |(want & ~cur);
    endfunction

endpackage

// File: rtl/opst_array.sv
module opst_array
    import opst_pkg::*;
#(
    parameter int AW = 6,
    parameter int SW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_we,
    input  logic [AW-1:0]        prog_addr,
    input  logic [7:0]           prog_data,
    input  logic                 erase_we,
    input  logic [(1<<SW)-1:0]   erase_mask,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_q,
    input  logic [AW-1:0]        chk_addr,
    output logic [7:0]           chk_q
);
    localparam int DEPTH = 1 << AW;
    localparam int OFS   = AW - SW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (erase_we) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_mask[SW'(i >> OFS)]) mem[i] <= ERASED_BYTE;
            end
        end else if (prog_we) begin
            // programming can only clear bits
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

    assign rd_q  = mem[rd_addr];
    assign chk_q = mem[chk_addr];

endmodule

// File: rtl/opst_ctrl.sv
module opst_ctrl
    import opst_pkg::*;
#(
    parameter int AW          = 6,
    parameter int SW          = 3,
    parameter int PULSE_LIMIT = 64,
    parameter int PROT_SHOW   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_start,
    input  opk_e               op_kind,
    input  logic [AW-1:0]      op_addr,
    input  logic [7:0]         op_data,
    input  logic [(1<<SW)-1:0] op_smask,
    input  logic [(1<<SW)-1:0] prot_mask,
    input  logic               op_done,
    input  logic               rst_cmd,
    input  logic               rd_en,
    input  logic [7:0]         cur_q,
    output ost_e               st,
    output logic               tog,
    output op_ctx_t            ctx,
    output logic [AW-1:0]      pa,
    output logic [(1<<SW)-1:0] req_mask,
    output logic               prog_we,
    output logic               erase_we,
    output logic [(1<<SW)-1:0] erase_mask
);
    localparam int NS      = 1 << SW;
    localparam int OFS     = AW - SW;
    localparam int CNT_MAX = (PULSE_LIMIT > PROT_SHOW) ? PULSE_LIMIT : PROT_SHOW;
    localparam int CW      = $clog2(CNT_MAX + 1);

    ost_e          st_q;
    logic          tog_q;
    op_ctx_t       ctx_q;
    logic [AW-1:0] pa_q;
    logic [NS-1:0] req_q;
    logic [NS-1:0] eff_q;
    logic          raise_q;
    logic [CW-1:0] cnt_q;

    logic [SW-1:0] sec;
    logic [NS-1:0] sec_1h;
    logic [NS-1:0] req_n;
    logic [NS-1:0] eff_n;
    logic          start_ok;
    logic          done_ok;

    assign sec      = op_addr[AW-1:OFS];
    assign sec_1h   = NS'(1) << sec;
    assign start_ok = op_start && (op_kind != OPK_NONE);

    always_comb begin
        case (op_kind)
            OPK_PROG:   req_n = sec_1h;
            OPK_SERASE: req_n = op_smask;
            OPK_CERASE: req_n = '1;
            default:    req_n = '0;
        endcase
    end

    assign eff_n   = req_n & ~prot_mask;
    assign done_ok = (st_q == ST_BUSY) && op_done && !raise_q;

    assign prog_we    = done_ok && (ctx_q.kind == OPK_PROG);
    assign erase_we   = done_ok && (ctx_q.kind != OPK_PROG);
    assign erase_mask = eff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tog_q   <= 1'b0;
            ctx_q   <= '{kind: OPK_NONE, pdata: 8'h00};
            pa_q    <= '0;
            req_q   <= '0;
            eff_q   <= '0;
            raise_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (st_q != ST_IDLE && rd_en) tog_q <= ~tog_q;
            case (st_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        ctx_q   <= '{kind: op_kind, pdata: op_data};
                        pa_q    <= op_addr;
                        req_q   <= req_n;
                        eff_q   <= eff_n;
                        raise_q <= (op_kind == OPK_PROG) && raises_bit(cur_q, op_data);
                        cnt_q   <= '0;
                        tog_q   <= 1'b0;
                        st_q    <= (eff_n == '0) ? ST_SHOW : ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (done_ok)                            st_q  <= ST_IDLE;
                    else if (cnt_q == CW'(PULSE_LIMIT - 1)) st_q  <= ST_FAIL;
                    else                                    cnt_q <= cnt_q + 1'b1;
                end
                ST_FAIL: begin
                    if (rst_cmd) st_q <= ST_IDLE;
                end
                ST_SHOW: begin
                    if (cnt_q == CW'(PROT_SHOW - 1)) st_q  <= ST_IDLE;
                    else                             cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st       = st_q;
    assign tog      = tog_q;
    assign ctx      = ctx_q;
    assign pa       = pa_q;
    assign req_mask = req_q;

endmodule

// File: rtl/opst_fmt.sv
module opst_fmt
    import opst_pkg::*;
#(
    parameter int AW = 6,
    parameter int SW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    input  ost_e               st,
    input  logic               tog,
    input  op_ctx_t            ctx,
    input  logic [(1<<SW)-1:0] req_mask,
    input  logic               win_open,
    input  logic [7:0]         arr_q,
    output logic [7:0]         rd_data
);
    localparam int OFS = AW - SW;

    logic       in_sel;
    logic       fl;
    logic [7:0] view;
    logic [7:0] rd_q;

    assign in_sel = req_mask[rd_addr[AW-1:OFS]];
    assign fl     = (st == ST_FAIL);

    always_comb begin
        if (st == ST_IDLE)             view = arr_q;
        else if (ctx.kind == OPK_PROG) view = prog_status(ctx.pdata[7], tog, fl);
        else if (in_sel)               view = erase_status(tog, fl, win_open);
        else                           view = arr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= 8'h00;
        else if (rd_en) rd_q <= view;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/opst_status_gen.sv
module opst_status_gen
    import opst_pkg::*;
#(
    parameter int AW          = 6,
    parameter int SW          = 3,
    parameter int PULSE_LIMIT = 64,
    parameter int PROT_SHOW   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_start,
    input  logic [1:0]         op_kind,
    input  logic [AW-1:0]      op_addr,
    input  logic [7:0]         op_data,
    input  logic [(1<<SW)-1:0] op_smask,
    input  logic [(1<<SW)-1:0] prot_mask,
    input  logic               op_done,
    input  logic               win_open,
    input  logic               rst_cmd,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_data
);
    localparam int NS = 1 << SW;

    ost_e          st;
    logic          tog;
    op_ctx_t       ctx;
    logic [AW-1:0] pa;
    logic [NS-1:0] req_mask;
    logic          prog_we;
    logic          erase_we;
    logic [NS-1:0] erase_mask;
    logic [7:0]    arr_q;
    logic [7:0]    cur_q;

    opst_ctrl #(.AW(AW), .SW(SW), .PULSE_LIMIT(PULSE_LIMIT), .PROT_SHOW(PROT_SHOW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .op_start   (op_start),
        .op_kind    (opk_e'(op_kind)),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .op_smask   (op_smask),
        .prot_mask  (prot_mask),
        .op_done    (op_done),
        .rst_cmd    (rst_cmd),
        .rd_en      (rd_en),
        .cur_q      (cur_q),
        .st         (st),
        .tog        (tog),
        .ctx        (ctx),
        .pa         (pa),
        .req_mask   (req_mask),
        .prog_we    (prog_we),
        .erase_we   (erase_we),
        .erase_mask (erase_mask)
    );

    opst_array #(.AW(AW), .SW(SW)) array_i (
        .clk        (clk),
        .rst        (rst),
        .prog_we    (prog_we),
        .prog_addr  (pa),
        .prog_data  (ctx.pdata),
        .erase_we   (erase_we),
        .erase_mask (erase_mask),
        .rd_addr    (rd_addr),
        .rd_q       (arr_q),
        .chk_addr   (op_addr),
        .chk_q      (cur_q)
    );

    opst_fmt #(.AW(AW), .SW(SW)) fmt_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .st       (st),
        .tog      (tog),
        .ctx      (ctx),
        .req_mask (req_mask),
        .win_open (win_open),
        .arr_q    (arr_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/opst_status_gen_chk.sv
module opst_status_gen_chk
    import opst_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       op_done,
    input logic       rst_cmd,
    input ost_e       st,
    input logic       tog,
    input logic [7:0] arr_q,
    input logic       prog_we,
    input logic       erase_we
);
    p_idle_data_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && rd_en) |=> (rd_data == $past(arr_q)));

    p_tog_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && rd_en) |=> (tog != $past(tog)));

    p_fail_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAIL && rd_en) |=> rd_data[5]);

    p_fail_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAIL && !rst_cmd) |=> (st == ST_FAIL));

    p_single_write_r7: assert property (@(posedge clk) disable iff (rst)
        !(prog_we && erase_we));

    p_show_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHOW) |-> !(prog_we || erase_we));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !op_done) |=> (st == ST_BUSY || st == ST_FAIL));

endmodule

bind opst_status_gen opst_status_gen_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .op_done  (op_done),
    .rst_cmd  (rst_cmd),
    .st       (st),
    .tog      (tog),
    .arr_q    (arr_q),
    .prog_we  (prog_we),
    .erase_we (erase_we)
);

// File: tb/opst_status_gen_tb_top.sv
module opst_status_gen_tb_top;
    localparam int AW = 6;
    localparam int SW = 3;
    localparam int NS = 1 << SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_start = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = 8'h00;
    logic [NS-1:0] op_smask = '0;
    logic [NS-1:0] prot_mask = '0;
    logic          op_done = 1'b0;
    logic          win_open = 1'b0;
    logic          rst_cmd = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    opst_status_gen #(.AW(AW), .SW(SW), .PULSE_LIMIT(64), .PROT_SHOW(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .op_smask  (op_smask),
        .prot_mask (prot_mask),
        .op_done   (op_done),
        .win_open  (win_open),
        .rst_cmd   (rst_cmd),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // program table: {address, data, first status read}
    localparam logic [21:0] PVEC [4] = '{
        {6'd5,  8'hA5, 8'h00},
        {6'd5,  8'h21, 8'h80},
        {6'd12, 8'h7F, 8'h80},
        {6'd63, 8'h00, 8'h80}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic rd(input logic [AW-1:0] a, input string req, input logic [7:0] exp);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic start(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [NS-1:0] m);
        op_start = 1'b1; op_kind = k; op_addr = a; op_data = d; op_smask = m;
        @(negedge clk);
        op_start = 1'b0; op_kind = 2'b00;
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic pulse_rcmd();
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: erased after reset
        rd(6'd0, "R1 reset read", 8'hFF);
        rd(6'd40, "R1 reset read", 8'hFF);

        // table walk: programs with status, toggle and readback
        for (int i = 0; i < 4; i++) begin
            logic [5:0] a;
            logic [7:0] d;
            logic [7:0] s;
            {a, d, s} = PVEC[i];
            start(2'b01, a, d, '0);
            rd(a, "R2 program status", s);
            rd(a, "R3 toggle second read", s | 8'h40);
            pulse_done();
            rd(a, "R2 program readback", d);
            rd(a, "R3 idle read no toggle", d);
        end

        // R4: raise 0->1 at addr 5 (holds 21h), ask for 23h
        start(2'b01, 6'd5, 8'h23, '0);
        rd(6'd5, "R2 status before fail", 8'h80);
        pulse_done();
        wait_cyc(80);
        rd(6'd5, "R4 fail flag", 8'hE0);
        rd(6'd5, "R4 fail toggling", 8'hA0);
        pulse_rcmd();
        rd(6'd5, "R5 data after reset cmd", 8'h21);
        start(2'b01, 6'd5, 8'h01, '0);
        rd(6'd5, "R5 fail cleared on next op", 8'h80);
        pulse_done();
        rd(6'd5, "R2 program after recovery", 8'h01);

        // R4: valid program that never gets completion times out
        start(2'b01, 6'd30, 8'h55, '0);
        wait_cyc(80);
        rd(6'd30, "R4 timeout fail", 8'hA0);
        pulse_rcmd();
        rd(6'd30, "R5 timeout target unchanged", 8'hFF);

        // R9: start and reset command ignored while busy
        start(2'b01, 6'd20, 8'hF0, '0);
        rd(6'd20, "R2 status F0", 8'h00);
        start(2'b01, 6'd21, 8'h00, '0);
        pulse_rcmd();
        rd(6'd20, "R9 still busy", 8'h40);
        pulse_done();
        rd(6'd20, "R9 first op done", 8'hF0);
        rd(6'd21, "R9 second op dropped", 8'hFF);

        // R6/R7: sector erase of sector 1
        win_open = 1'b1;
        start(2'b10, 6'd0, 8'h00, 8'h02);
        rd(6'd12, "R6 erase status window open", 8'h00);
        win_open = 1'b0;
        rd(6'd12, "R6 erase status window closed", 8'h48);
        rd(6'd63, "R6 outside sector reads data", 8'h00);
        pulse_done();
        rd(6'd12, "R7 erased byte", 8'hFF);
        rd(6'd8, "R7 erased byte", 8'hFF);
        rd(6'd5, "R7 other sector kept", 8'h01);

        // R7/R8: chip erase with sector 7 protected
        prot_mask = 8'h80;
        start(2'b11, 6'd0, 8'h00, '0);
        rd(6'd5, "R6 chip erase status", 8'h08);
        pulse_done();
        rd(6'd5, "R7 chip erased", 8'hFF);
        rd(6'd20, "R7 chip erased", 8'hFF);
        rd(6'd63, "R8 protected sector kept", 8'h00);

        // R8: program to a protected sector
        prot_mask = 8'h01;
        start(2'b01, 6'd5, 8'h0F, '0);
        rd(6'd5, "R8 protected status shown", 8'h80);
        wait_cyc(6);
        rd(6'd5, "R8 protected data unchanged", 8'hFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule